// File: doc/BRIEF.md
# Robbed-Bit Signaling Debouncer

This block keeps a clean copy of the four-bit signaling state (A, B, C, D) for every channel of a 24-channel T1 stream. A bit-robbing extractor upstream offers one nibble per channel per superframe on `sig_valid`/`sig_slot`/`sig_nib` and marks the end of each superframe with `sf_end`. The block does not trust a single sample. It holds each channel's last nibble as a candidate and moves it into the channel's signaling store only when the next superframe brings the same nibble again.

Software or a downstream signaling consumer reads the debounced nibble through a combinational read port. A substitution mode can replace what that port returns with all ones or with a programmed code, and it leaves the store untouched. A freeze input stops all store updates. Every committed change sets a sticky per-channel flag. The flags are grouped eight channels to a group, and reading a group clears it. The interrupt output is raised while any flag is set, provided signaling is enabled and the interrupt is unmasked.

Top module: `rbs_debounce`

## Requirements
- R1: A channel's store takes a new nibble only at the `sf_end` edge that closes superframe N+1, and only when the channel delivered the same nibble in both superframe N and superframe N+1. The new value appears on `rd_nib` the cycle after that edge.
- R2: After reset every store reads 0, no flag is set and `irq` is 0. The first superframe after reset never commits. If the two nibbles disagree, the store keeps its value. A superframe in which a channel delivers nothing breaks the pairing, so two matching superframes must follow before the store can change.
- R3: While `freeze` is 1, no store changes and no flag is set. Candidates keep being tracked, so after release a single superframe that matches the last candidate commits.
- R4: A commit that changes a store sets that channel's flag. Channel s maps to group s/8, bit s%8. A matching pair equal to the value already stored sets no flag.
- R5: `grp_data` shows the flags of group `grp_sel` combinationally. Pulsing `grp_rd` clears that group at the next edge, and a flag set on that same edge survives. A `grp_sel` of 3 reads 0 and clears nothing.
- R6: `subst_mode` 0 and 3 return the stored nibble. Mode 1 returns 4'b1111. Mode 2 returns `subst_code`. The store is not affected, so returning to mode 0 shows the stored value again.
- R7: `irq` equals `irq_en` AND `rbs_enable` AND the OR of all flags.
- R8: If a channel sends several valid nibbles in one superframe, the last one counts. A valid nibble in the same cycle as `sf_end` belongs to the superframe that follows.
- R9: A `rd_slot` of 24 or more reads 0 in every substitution mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sig_valid | input | 1 | Extracted nibble strobe |
| sig_slot | input | 5 | Channel of the extracted nibble |
| sig_nib | input | 4 | Extracted ABCD nibble |
| sf_end | input | 1 | Superframe boundary strobe |
| freeze | input | 1 | Hold all stores and flags |
| rbs_enable | input | 1 | Robbed-bit signaling in use |
| subst_mode | input | 2 | 0/3 pass, 1 all ones, 2 programmed code |
| subst_code | input | 4 | Code returned in mode 2 |
| rd_slot | input | 5 | Channel to read |
| rd_nib | output | 4 | Debounced (or substituted) nibble |
| grp_sel | input | 2 | Flag group to read |
| grp_rd | input | 1 | Read strobe, clears the selected group |
| grp_data | output | 8 | Flags of the selected group |
| irq_en | input | 1 | Interrupt mask |
| irq | output | 1 | Change interrupt |

## Verification
A vector table drives pairs of superframes on different channels: equal non-zero pairs, unequal pairs, an equal all-zero pair and the all-ones pair. Equal non-zero pairs must commit and flag. Unequal pairs must not commit. The all-zero pair matches the reset value, so it separates "values matched" from "value changed". Directed sequences then cover a missing superframe between two matching ones, which must not commit, and several nibbles per superframe, which checks the last-wins rule. A nibble arriving on the boundary cycle checks which superframe it belongs to. Freeze with later release, a repeat of the stored value, read-to-clear of one group next to an untouched group, the interrupt gating, and every substitution mode, including an out-of-range read channel, complete the set.

// File: rtl/rbs_pkg.sv
package rbs_pkg;
   typedef enum logic [1:0] {
      SUB_NONE = 2'd0,
      SUB_ONES = 2'd1,
      SUB_CODE = 2'd2,
      SUB_RSVD = 2'd3
   } subst_e;
endpackage

// File: rtl/rbs_slot_cell.sv
// One channel: candidate tracking, pair compare, committed store.
module rbs_slot_cell #(
   parameter int NIB_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cap,
   input  logic [NIB_W-1:0] nib_in,
   input  logic             sf_end,
   input  logic             freeze,
   output logic [NIB_W-1:0] store_o,
   output logic             changed_o
);
   logic [NIB_W-1:0] cur_q, cand_q, store_q;
   logic             got_q, cand_ok_q;
   logic             agree;

   // a pair exists when this superframe and the previous one both delivered
   assign agree     = got_q & cand_ok_q & (cur_q == cand_q);
   assign changed_o = sf_end & agree & ~freeze & (cur_q != store_q);
   assign store_o   = store_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cur_q     <= '0;
         cand_q    <= '0;
         store_q   <= '0;
         got_q     <= 1'b0;
         cand_ok_q <= 1'b0;
      end else if (sf_end) begin
         if (changed_o) store_q <= cur_q;
         cand_q    <= cur_q;
         cand_ok_q <= got_q;
         got_q     <= cap;
         if (cap) cur_q <= nib_in;
      end else if (cap) begin
         cur_q <= nib_in;
         got_q <= 1'b1;
      end
   end
endmodule

// File: rtl/rbs_chg_flags.sv
// Sticky per-channel change flags, grouped, clear on read.
module rbs_chg_flags #(
   parameter int NUM_SLOTS  = 24,
   parameter int GROUP_SIZE = 8,
   parameter int NUM_GROUPS = 3,
   parameter int GRP_W      = 2
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [NUM_SLOTS-1:0]  set_i,
   input  logic                  rd_i,
   input  logic [GRP_W-1:0]      sel_i,
   output logic [GROUP_SIZE-1:0] data_o,
   output logic [NUM_SLOTS-1:0]  flags_o
);
   logic [NUM_SLOTS-1:0] flags_q;
   logic [NUM_SLOTS-1:0] clr_mask;

   for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_clr
      assign clr_mask[g*GROUP_SIZE +: GROUP_SIZE] =
         {GROUP_SIZE{rd_i && (sel_i == GRP_W'(g))}};
   end

   always_comb begin
      data_o = '0;
      for (int g = 0; g < NUM_GROUPS; g++) begin
         if (sel_i == GRP_W'(g)) data_o = flags_q[g*GROUP_SIZE +: GROUP_SIZE];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) flags_q <= '0;
      else        flags_q <= (flags_q & ~clr_mask) | set_i;
   end

   assign flags_o = flags_q;
endmodule

// File: rtl/rbs_out_sel.sv
// Read mux plus optional substitution.
module rbs_out_sel #(
   parameter int NUM_SLOTS = 24,
   parameter int NIB_W     = 4,
   parameter int SLOT_W    = 5,
   parameter bit SUBST_EN  = 1'b1
) (
   input  logic [NUM_SLOTS*NIB_W-1:0] store_flat,
   input  logic [SLOT_W-1:0]          rd_slot,
   input  logic [1:0]                 mode,
   input  logic [NIB_W-1:0]           code,
   output logic [NIB_W-1:0]           rd_nib
);
   import rbs_pkg::*;
   logic [NIB_W-1:0] raw;
   logic             slot_ok;

   always_comb begin
      raw     = '0;
      slot_ok = 1'b0;
      for (int s = 0; s < NUM_SLOTS; s++) begin
         if (rd_slot == SLOT_W'(s)) begin
            raw     = store_flat[s*NIB_W +: NIB_W];
            slot_ok = 1'b1;
         end
      end
   end

   if (SUBST_EN) begin : g_subst
      subst_e m;
      assign m = subst_e'(mode);
      always_comb begin
         unique case (m)
            SUB_ONES: rd_nib = slot_ok ? {NIB_W{1'b1}} : '0;
            SUB_CODE: rd_nib = slot_ok ? code : '0;
            default:  rd_nib = raw;
         endcase
      end
   end else begin : g_pass
      logic [2+NIB_W-1:0] unused_in;
      assign unused_in = {mode, code};
      assign rd_nib    = raw;
   end
endmodule

// File: rtl/rbs_debounce.sv
module rbs_debounce #(
   parameter int NUM_SLOTS  = 24,
   parameter int NIB_W      = 4,
   parameter int GROUP_SIZE = 8,
   parameter bit SUBST_EN   = 1'b1,
   localparam int SLOT_W     = $clog2(NUM_SLOTS),
   localparam int NUM_GROUPS = NUM_SLOTS / GROUP_SIZE,
   localparam int GRP_W      = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS + 1) : 1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  sig_valid,
   input  logic [SLOT_W-1:0]     sig_slot,
   input  logic [NIB_W-1:0]      sig_nib,
   input  logic                  sf_end,
   input  logic                  freeze,
   input  logic                  rbs_enable,
   input  logic [1:0]            subst_mode,
   input  logic [NIB_W-1:0]      subst_code,
   input  logic [SLOT_W-1:0]     rd_slot,
   output logic [NIB_W-1:0]      rd_nib,
   input  logic [GRP_W-1:0]      grp_sel,
   input  logic                  grp_rd,
   output logic [GROUP_SIZE-1:0] grp_data,
   input  logic                  irq_en,
   output logic                  irq
);
   // elaboration-time parameter checks
   if (NUM_SLOTS < 2) begin : g_bad_slots
      $error("rbs_debounce: NUM_SLOTS must be at least 2");
   end
   if (NIB_W < 1) begin : g_bad_nib
      $error("rbs_debounce: NIB_W must be positive");
   end
   if ((GROUP_SIZE < 1) || (NUM_SLOTS % GROUP_SIZE != 0)) begin : g_bad_grp
      $error("rbs_debounce: GROUP_SIZE must divide NUM_SLOTS");
   end

   logic [NUM_SLOTS*NIB_W-1:0] store_flat;
   logic [NUM_SLOTS-1:0]       commit_vec;
   logic [NUM_SLOTS-1:0]       chg_flat;

   for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
      logic cap;
      assign cap = sig_valid && (sig_slot == SLOT_W'(s));
      rbs_slot_cell #(.NIB_W(NIB_W)) u_cell (
         .clk       (clk),
         .rst_n     (rst_n),
         .cap       (cap),
         .nib_in    (sig_nib),
         .sf_end    (sf_end),
         .freeze    (freeze),
         .store_o   (store_flat[s*NIB_W +: NIB_W]),
         .changed_o (commit_vec[s])
      );
   end

   rbs_chg_flags #(
      .NUM_SLOTS (NUM_SLOTS),
      .GROUP_SIZE(GROUP_SIZE),
      .NUM_GROUPS(NUM_GROUPS),
      .GRP_W     (GRP_W)
   ) u_flags (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (commit_vec),
      .rd_i   (grp_rd),
      .sel_i  (grp_sel),
      .data_o (grp_data),
      .flags_o(chg_flat)
   );

   rbs_out_sel #(
      .NUM_SLOTS(NUM_SLOTS),
      .NIB_W    (NIB_W),
      .SLOT_W   (SLOT_W),
      .SUBST_EN (SUBST_EN)
   ) u_out (
      .store_flat(store_flat),
      .rd_slot   (rd_slot),
      .mode      (subst_mode),
      .code      (subst_code),
      .rd_nib    (rd_nib)
   );

   assign irq = irq_en & rbs_enable & (|chg_flat);
endmodule

// File: rtl/rbs_debounce_chk.sv
module rbs_debounce_chk #(
   parameter int NUM_SLOTS  = 24,
   parameter int NIB_W      = 4,
   parameter int GROUP_SIZE = 8,
   parameter int SLOT_W     = 5,
   parameter int GRP_W      = 2
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic                       sf_end,
   input logic                       freeze,
   input logic                       rbs_enable,
   input logic                       irq_en,
   input logic                       irq,
   input logic                       grp_rd,
   input logic [GRP_W-1:0]           grp_sel,
   input logic [SLOT_W-1:0]          rd_slot,
   input logic [NIB_W-1:0]           rd_nib,
   input logic [NUM_SLOTS*NIB_W-1:0] store_flat,
   input logic [NUM_SLOTS-1:0]       chg_flat
);
   // R1: stores move only on the edge a boundary strobe was seen
   a_r1_store_on_boundary: assert property (@(posedge clk) disable iff (!rst_n)
      (store_flat != $past(store_flat)) |-> $past(sf_end));

   // R3: freeze holds every store
   a_r3_freeze_holds: assert property (@(posedge clk) disable iff (!rst_n)
      freeze |=> $stable(store_flat));

   // R4: a newly raised flag comes with a store change
   a_r4_flag_needs_commit: assert property (@(posedge clk) disable iff (!rst_n)
      ((chg_flat & ~$past(chg_flat)) != '0) |-> (store_flat != $past(store_flat)));

   // R5: reading group 0 without a boundary leaves it clear
   a_r5_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (grp_rd && grp_sel == GRP_W'(0) && !sf_end) |=> (chg_flat[GROUP_SIZE-1:0] == '0));

   // R7: interrupt suppressed when signaling off or masked
   a_r7_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
      (!rbs_enable || !irq_en) |-> !irq);

   // R9: out-of-range read channel returns zero
   a_r9_range_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_slot >= SLOT_W'(NUM_SLOTS)) |-> (rd_nib == '0));
endmodule

bind rbs_debounce rbs_debounce_chk #(
   .NUM_SLOTS (NUM_SLOTS),
   .NIB_W     (NIB_W),
   .GROUP_SIZE(GROUP_SIZE),
   .SLOT_W    (SLOT_W),
   .GRP_W     (GRP_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .sf_end    (sf_end),
   .freeze    (freeze),
   .rbs_enable(rbs_enable),
   .irq_en    (irq_en),
   .irq       (irq),
   .grp_rd    (grp_rd),
   .grp_sel   (grp_sel),
   .rd_slot   (rd_slot),
   .rd_nib    (rd_nib),
   .store_flat(store_flat),
   .chg_flat  (chg_flat)
);

// File: tb/rbs_debounce_bench.sv
`timescale 1ns/1ps
module rbs_debounce_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sig_valid = 1'b0;
   logic [4:0] sig_slot = '0;
   logic [3:0] sig_nib = '0;
   logic       sf_end = 1'b0;
   logic       freeze = 1'b0;
   logic       rbs_enable = 1'b1;
   logic [1:0] subst_mode = 2'd0;
   logic [3:0] subst_code = 4'd0;
   logic [4:0] rd_slot = '0;
   logic [3:0] rd_nib;
   logic [1:0] grp_sel = '0;
   logic       grp_rd = 1'b0;
   logic [7:0] grp_data;
   logic       irq_en = 1'b1;
   logic       irq;

   int n_run = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   rbs_debounce u_rbs_debounce (
      .clk(clk), .rst_n(rst_n), .sig_valid(sig_valid), .sig_slot(sig_slot),
      .sig_nib(sig_nib), .sf_end(sf_end), .freeze(freeze),
      .rbs_enable(rbs_enable), .subst_mode(subst_mode), .subst_code(subst_code),
      .rd_slot(rd_slot), .rd_nib(rd_nib), .grp_sel(grp_sel), .grp_rd(grp_rd),
      .grp_data(grp_data), .irq_en(irq_en), .irq(irq)
   );

   // slot, first nibble, second nibble, expected store
   localparam int unsigned VEC [8][4] = '{
      '{0,  3,  3,  3}, '{5,  7,  2,  0}, '{9,  0,  0,  0}, '{13, 15, 15, 15},
      '{16, 1,  8,  0}, '{20, 12, 12, 12}, '{23, 6,  6,  6}, '{7,  10, 11, 0}
   };

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic check(input string req, input int act, input int exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic put(input int s, input int n);
      sig_valid = 1'b1; sig_slot = 5'(s); sig_nib = 4'(n);
      tick();
      sig_valid = 1'b0;
   endtask

   task automatic boundary();
      sf_end = 1'b1;
      tick();
      sf_end = 1'b0;
   endtask

   task automatic rd(input int s, output int v);
      rd_slot = 5'(s); #1; v = int'(rd_nib);
   endtask

   task automatic grp(input int g, output int v);
      grp_sel = 2'(g); #1; v = int'(grp_data);
   endtask

   task automatic clear_grp(input int g);
      grp_sel = 2'(g); grp_rd = 1'b1;
      tick();
      grp_rd = 1'b0;
   endtask

   initial begin
      int v;
      repeat (3) tick();
      rst_n = 1'b1;
      tick();
      // R2 reset state
      rd(0, v);  check("R2 reset store", v, 0);
      grp(0, v); check("R2 reset flags", v, 0);
      check("R2 reset irq", int'(irq), 0);

      // R1/R4 vector table
      for (int i = 0; i < 8; i++) begin
         int s, a, b, e, f;
         s = int'(VEC[i][0]); a = int'(VEC[i][1]);
         b = int'(VEC[i][2]); e = int'(VEC[i][3]);
         put(s, a); boundary();
         put(s, b); boundary();
         rd(s, v);  check("R1 table store", v, e);
         grp(s / 8, v);
         f = (a == b && a != 0) ? 1 : 0;
         check("R4 table flag", (v >> (s % 8)) & 1, f);
      end

      // R7 interrupt gating
      #1; check("R7 irq on", int'(irq), 1);
      rbs_enable = 1'b0; #1; check("R7 irq rbs off", int'(irq), 0);
      rbs_enable = 1'b1; irq_en = 1'b0; #1; check("R7 irq masked", int'(irq), 0);
      irq_en = 1'b1;

      // R5 read-clear
      grp(0, v); check("R5 group0 before read", v, 8'h01);
      clear_grp(0);
      grp(0, v); check("R5 group0 after read", v, 0);
      grp(2, v); check("R5 group2 untouched", v, 8'h90);
      grp(3, v); check("R5 out-of-range group", v, 0);

      // R3 freeze
      freeze = 1'b1;
      put(3, 9); boundary(); put(3, 9); boundary();
      rd(3, v);  check("R3 frozen store", v, 0);
      grp(0, v); check("R3 frozen flag", v, 0);
      freeze = 1'b0;
      put(3, 9); boundary();
      rd(3, v);  check("R3 commit after release", v, 9);
      grp(0, v); check("R3 flag after release", v, 8'h08);

      // R5 set and clear on the same edge: flag survives
      clear_grp(0);
      put(2, 4); boundary();
      put(2, 4); sf_end = 1'b1; grp_sel = 2'd0; grp_rd = 1'b1;
      tick();
      sf_end = 1'b0; grp_rd = 1'b0;
      grp(0, v); check("R5 set beats clear", v, 8'h04);
      clear_grp(0);

      // R4 same value again: no flag
      put(3, 9); boundary();
      rd(3, v);  check("R4 repeat store", v, 9);
      grp(0, v); check("R4 repeat no flag", v, 0);

      // R2 missing superframe breaks pairing
      put(4, 6); boundary();
      boundary();
      put(4, 6); boundary();
      rd(4, v);  check("R2 gap no commit", v, 0);
      put(4, 6); boundary();
      rd(4, v);  check("R2 commit after pair", v, 6);

      // R8 last wins, boundary-cycle nibble goes to next superframe
      put(10, 2); put(10, 5);
      sig_valid = 1'b1; sig_slot = 5'd10; sig_nib = 4'd5; sf_end = 1'b1;
      tick();
      sig_valid = 1'b0; sf_end = 1'b0;
      boundary();
      rd(10, v); check("R8 boundary nibble", v, 5);

      // R6 substitution
      subst_mode = 2'd1; rd(3, v); check("R6 all ones", v, 15);
      subst_mode = 2'd2; subst_code = 4'd6; rd(3, v); check("R6 code", v, 6);
      subst_mode = 2'd3; rd(3, v); check("R6 reserved passes", v, 9);
      subst_mode = 2'd0; rd(3, v); check("R6 store kept", v, 9);

      // R9 out-of-range read
      rd(30, v); check("R9 range mode0", v, 0);
      subst_mode = 2'd1; rd(30, v); check("R9 range mode1", v, 0);
      subst_mode = 2'd0;

      if (!done) begin
         done = 1'b1;
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_run++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end
endmodule